// File: doc/BRIEF.md
# Multi-Channel Timer Unit with Prescaler

This block holds a group of down-counting timer channels (1 to 8, set at build time) that share one 16-bit prescaler. The prescaler counts down once per clock. Each time it passes zero it reloads from its own reload register and produces a one-cycle tick, which is common to all channels. An enabled channel decrements on every tick. When it underflows from zero, it can raise its own interrupt line, latch a pending flag, and either restart from its reload value or stop.

Software reaches the block through a plain 32-bit register port with valid, write, address and data. Only the low eight address bits are decoded, and every access is a full word. The first 16 bytes hold the unit registers. Each channel then has a 16-byte bank. A read-only capability word reports how the unit was built.

Top module: `mtimer_unit`

## Requirements
- R1: The word at offset 0x08 reads as the capability value: channel count (modulo 8) in bits [2:0], base interrupt line in bits [7:3], and bits 8 and 9 set. With the defaults (2 channels, base line 8) it reads 0x342. Writes to it change nothing.
- R2: The prescaler value (offset 0x00) and the prescaler reload (offset 0x04) are 16 bits wide and read as zero after reset. Data bits above bit 15 are dropped when either is written.
- R3: A write to the prescaler reload also loads the prescaler value in the same clock edge.
- R4: The prescaler value falls by one each clock. In the clock after it reads zero, it holds the reload value again, so ticks repeat every reload+1 clocks.
- R5: Channel n owns offsets 0x10+0x10*n. Its counter is at +0x0, its reload at +0x4 and its control word at +0x8. Counter and reload are full 32-bit read/write registers.
- R6: Reads of offset +0xC in any bank, and of banks above the built channel count, return zero. Writes there have no effect. Address bits above bit 7 are ignored.
- R7: Control bit 0 enables a channel, which then decrements on each tick. A tick that finds the counter at zero is an underflow. If restart (bit 1) is set, the counter reloads, so the period is reload+1 ticks.
- R8: On an underflow with restart clear, the enable bit clears and the counter stays at zero.
- R9: On an underflow with interrupt enable (bit 3) set, the channel's interrupt output is high for exactly the next cycle and pending (bit 4) becomes 1. A control write with bit 4 at 1 clears pending, and with bit 4 at 0 it keeps pending. An interrupt output is never high while its pending bit is clear.
- R10: A control write with bit 2 set copies the reload value into the counter. Bit 2 always reads as zero, as do bits 5 and up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; bits [7:2] decoded |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for req_addr (combinational) |
| irq | output | NUM_CH | One interrupt pulse line per channel |

## Verification
The prescaler value can be read back, so a wrong prescaler state shows at the port in the very cycle after the fault: it breaks the strict down-count or the reload seen on reads of offset 0x00. A wrong channel count or control state shows up instead as an interrupt pulse in the wrong cycle. It also appears as a wrong control readback (pending, enable or load bit), at the latest one channel period after the fault. The bench therefore samples the interrupt lines on every cycle around the expected underflow, and it reads control words right after each underflow.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    // control word bit positions (software-visible)
    localparam int unsigned CTL_EN = 0;
    localparam int unsigned CTL_RS = 1;
    localparam int unsigned CTL_LD = 2;
    localparam int unsigned CTL_IE = 3;
    localparam int unsigned CTL_PD = 4;

    typedef enum logic [1:0] {
        SLOT_CNT  = 2'd0,
        SLOT_RLD  = 2'd1,
        SLOT_CTL  = 2'd2,
        SLOT_NONE = 2'd3
    } slot_e;

    typedef struct packed {
        logic en;
        logic rs;
        logic ie;
        logic pd;
    } ctl_t;

    typedef struct packed {
        logic       hit_unit;
        logic       hit_chan;
        logic [3:0] chan;
        slot_e      slot;
    } dec_t;

    function automatic dec_t decode(input logic [7:0] a, input int unsigned nch);
        dec_t d;
        d.slot     = slot_e'(a[3:2]);
        d.hit_unit = (a[7:4] == 4'd0);
        d.chan     = a[7:4] - 4'd1;
        d.hit_chan = (a[7:4] != 4'd0) && ({1'b0, a[7:4]} <= 5'(nch));
        return d;
    endfunction

    function automatic logic [31:0] ctl_word(input ctl_t c);
        return {27'd0, c.pd, c.ie, 1'b0, c.rs, c.en};
    endfunction

endpackage

// File: rtl/mtimer_prescaler.sv
module mtimer_prescaler #(
    parameter int unsigned SCL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_val,
    input  logic             wr_rld,
    input  logic [31:0]      wdata,
    output logic [SCL_W-1:0] val_o,
    output logic [SCL_W-1:0] rld_o,
    output logic             tick_o
);
    logic [SCL_W-1:0] val_q, rld_q;
    logic             unused_hi;

    assign unused_hi = ^wdata;
    assign tick_o    = (val_q == '0);
    assign val_o     = val_q;
    assign rld_o     = rld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
            rld_q <= '0;
        end else if (wr_rld) begin
            rld_q <= wdata[SCL_W-1:0];
            val_q <= wdata[SCL_W-1:0];
        end else if (wr_val) begin
            val_q <= wdata[SCL_W-1:0];
        end else if (tick_o) begin
            val_q <= rld_q;
        end else begin
            val_q <= val_q - 1'b1;
        end
    end
endmodule

// File: rtl/mtimer_channel.sv
module mtimer_channel
    import mtimer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_cnt,
    input  logic             wr_rld,
    input  logic             wr_ctl,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output ctl_t             ctl_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] cnt_q, rld_q;
    ctl_t             ctl_q;
    logic             irq_q;
    logic             unused_hi;

    assign unused_hi = ^wdata;
    assign cnt_o     = cnt_q;
    assign rld_o     = rld_q;
    assign ctl_o     = ctl_q;
    assign irq_o     = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
            ctl_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr_rld) begin
                rld_q <= wdata[CNT_W-1:0];
            end
            if (wr_ctl) begin
                ctl_q.en <= wdata[CTL_EN];
                ctl_q.rs <= wdata[CTL_RS];
                ctl_q.ie <= wdata[CTL_IE];
                ctl_q.pd <= wdata[CTL_PD] ? 1'b0 : ctl_q.pd;
                if (wdata[CTL_LD]) begin
                    cnt_q <= rld_q;
                end
            end else if (wr_cnt) begin
                cnt_q <= wdata[CNT_W-1:0];
            end else if (tick && ctl_q.en) begin
                if (cnt_q == '0) begin
                    irq_q <= ctl_q.ie;
                    if (ctl_q.ie) begin
                        ctl_q.pd <= 1'b1;
                    end
                    if (ctl_q.rs) begin
                        cnt_q <= rld_q;
                    end else begin
                        ctl_q.en <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit
    import mtimer_pkg::*;
#(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned BASE_IRQ = 8,
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned SCL_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam logic [31:0] CAP_WORD = {22'd0, 1'b1, 1'b1, 5'(BASE_IRQ), 3'(NUM_CH)};

    dec_t             dec;
    logic             wr;
    logic             tick;
    logic [SCL_W-1:0] sc_val, sc_rld;
    logic [CNT_W-1:0] cnt_a [NUM_CH];
    logic [CNT_W-1:0] rld_a [NUM_CH];
    ctl_t             ctl_a [NUM_CH];
    logic [NUM_CH-1:0] pend_vec;
    logic             unused_addr;

    assign unused_addr = ^{req_addr[31:8], req_addr[1:0]};
    assign dec = decode(req_addr[7:0], NUM_CH);
    assign wr  = req_valid && req_write;

    mtimer_prescaler #(.SCL_W(SCL_W)) u_scl (
        .clk    (clk),
        .rst    (rst),
        .wr_val (wr && dec.hit_unit && dec.slot == SLOT_CNT),
        .wr_rld (wr && dec.hit_unit && dec.slot == SLOT_RLD),
        .wdata  (req_wdata),
        .val_o  (sc_val),
        .rld_o  (sc_rld),
        .tick_o (tick)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel = wr && dec.hit_chan && (dec.chan == 4'(g));

        mtimer_channel #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .wr_cnt (sel && dec.slot == SLOT_CNT),
            .wr_rld (sel && dec.slot == SLOT_RLD),
            .wr_ctl (sel && dec.slot == SLOT_CTL),
            .wdata  (req_wdata),
            .cnt_o  (cnt_a[g]),
            .rld_o  (rld_a[g]),
            .ctl_o  (ctl_a[g]),
            .irq_o  (irq[g])
        );
        assign pend_vec[g] = ctl_a[g].pd;
    end

    always_comb begin
        rsp_rdata = '0;
        if (dec.hit_unit) begin
            unique case (dec.slot)
                SLOT_CNT: rsp_rdata = 32'(sc_val);
                SLOT_RLD: rsp_rdata = 32'(sc_rld);
                SLOT_CTL: rsp_rdata = CAP_WORD;
                default:  rsp_rdata = '0;
            endcase
        end else if (dec.hit_chan) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (dec.chan == 4'(i)) begin
                    unique case (dec.slot)
                        SLOT_CNT: rsp_rdata = 32'(cnt_a[i]);
                        SLOT_RLD: rsp_rdata = 32'(rld_a[i]);
                        SLOT_CTL: rsp_rdata = ctl_word(ctl_a[i]);
                        default:  rsp_rdata = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk #(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned BASE_IRQ = 8,
    parameter int unsigned SCL_W    = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [31:0]       req_addr,
    input logic [31:0]       req_wdata,
    input logic [31:0]       rsp_rdata,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] pend,
    input logic [SCL_W-1:0]  sc_val
);
    localparam logic [31:0] CAP = {22'd0, 1'b1, 1'b1, 5'(BASE_IRQ), 3'(NUM_CH)};
    localparam logic [4:0]  NCH5 = 5'(NUM_CH);

    // R1
    cap_word_chk: assert property (@(posedge clk) disable iff (rst)
        (req_addr[7:0] == 8'h08) |-> (rsp_rdata == CAP));

    // R6
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (({1'b0, req_addr[7:4]} > NCH5) || (req_addr[3:2] == 2'b11)) |-> (rsp_rdata == 32'd0));

    // R3
    rld_loads_val_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr[7:0] == 8'h04)
        |=> (sc_val == $past(req_wdata[SCL_W-1:0])));

    // R4
    scl_countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (!(req_valid && req_write && req_addr[7:3] == 5'd0) && sc_val != '0)
        |=> (sc_val == $past(sc_val) - 1'b1));

    // R9
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq & ~pend) == '0));
endmodule

bind mtimer_unit mtimer_chk #(
    .NUM_CH   (NUM_CH),
    .BASE_IRQ (BASE_IRQ),
    .SCL_W    (SCL_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .irq       (irq),
    .pend      (pend_vec),
    .sc_val    (sc_val)
);

// File: tb/mtimer_unit_bench.sv
`timescale 1ns/1ps
module mtimer_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mtimer_unit u_mtimer_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VT [NV] = '{
        '{1'b0, 32'h08,  32'h0,        32'h342,      8'd1},  // R1 capability after reset
        '{1'b1, 32'h08,  32'hFFFFFFFF, 32'h0,        8'd1},  // R1 write ignored
        '{1'b0, 32'h08,  32'h0,        32'h342,      8'd1},
        '{1'b0, 32'h00,  32'h0,        32'h0,        8'd2},  // R2 reset zero
        '{1'b0, 32'h04,  32'h0,        32'h0,        8'd2},
        '{1'b1, 32'h14,  32'hDEADBEEF, 32'h0,        8'd5},
        '{1'b0, 32'h14,  32'h0,        32'hDEADBEEF, 8'd5},  // R5 ch0 reload
        '{1'b0, 32'h114, 32'h0,        32'hDEADBEEF, 8'd6},  // R6 address mod 256
        '{1'b0, 32'h108, 32'h0,        32'h342,      8'd6},
        '{1'b1, 32'h34,  32'h5,        32'h0,        8'd6},
        '{1'b0, 32'h34,  32'h0,        32'h0,        8'd6},  // R6 bank beyond count
        '{1'b0, 32'h0C,  32'h0,        32'h0,        8'd6},
        '{1'b0, 32'h1C,  32'h0,        32'h0,        8'd6},
        '{1'b1, 32'h24,  32'h7,        32'h0,        8'd10},
        '{1'b1, 32'h28,  32'h4,        32'h0,        8'd10},
        '{1'b0, 32'h20,  32'h0,        32'h7,        8'd10}, // R10 load copies reload
        '{1'b0, 32'h28,  32'h0,        32'h0,        8'd10}, // R10 load bit reads zero
        '{1'b1, 32'h20,  32'h55,       32'h0,        8'd5},
        '{1'b0, 32'h20,  32'h0,        32'h55,       8'd5}   // R5 ch1 counter
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #2 d = rsp_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2 chk("R9 irq low after reset", 32'(irq), 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VT[i].wr) wr(VT[i].addr, VT[i].data);
            else begin
                rd(VT[i].addr, d);
                chk($sformatf("R%0d vector %0d", VT[i].rq, i), d, VT[i].exp);
            end
        end

        // R2: value write truncated, then counts down to zero and stays (reload 0)
        wr(32'h00, 32'h0001_0002);
        req_addr = 32'h00;
        #2 chk("R2 value truncated", rsp_rdata, 32'h2);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk); #2;
            chk("R4 countdown to zero", rsp_rdata, (k == 1) ? 32'h1 : 32'h0);
        end

        // R3/R4: reload write loads value, then period of reload+1
        wr(32'h04, 32'hABCD_0003);
        req_addr = 32'h00;
        #2 chk("R3 reload loads value", rsp_rdata, 32'h3);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk); #2;
            chk("R4 prescaler sequence", rsp_rdata, 32'((3 - (k % 4))));
        end
        rd(32'h04, d);
        chk("R2 reload truncated", d, 32'h3);
        wr(32'h04, 32'h0);

        // R7/R9: ch0 periodic, reload 5, tick every clock
        wr(32'h14, 32'h5);
        wr(32'h18, 32'hF);
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk); #1;
            chk($sformatf("R7 R9 ch0 irq k=%0d", k), 32'(irq[0]), (k == 6) ? 32'h1 : 32'h0);
        end
        rd(32'h18, d);
        chk("R9 R10 ch0 control pending", d, 32'h1B);
        wr(32'h18, 32'h10);
        rd(32'h18, d);
        chk("R9 pending cleared by 1", d, 32'h0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); #1;
            chk("R9 no irq after disable", 32'(irq[0]), 32'h0);
        end

        // R8: ch1 one-shot from 2
        wr(32'h20, 32'h2);
        wr(32'h28, 32'h9);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk); #1;
            chk($sformatf("R8 ch1 irq k=%0d", k), 32'(irq[1]), (k == 3) ? 32'h1 : 32'h0);
        end
        rd(32'h28, d);
        chk("R8 enable cleared", d, 32'h18);
        rd(32'h20, d);
        chk("R8 counter held at zero", d, 32'h0);
        wr(32'h28, 32'h8);
        rd(32'h28, d);
        chk("R9 pending kept by 0", d, 32'h18);
        wr(32'h28, 32'h10);
        rd(32'h28, d);
        chk("R9 pending cleared", d, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule